// File: doc/BRIEF.md
# Gated Accumulator Register

This block is the working register of a simple single-accumulator processor. It bundles the register with its operand datapath and its control gating. A one-hot opcode decoder and a one-hot timing-state counter sit outside the block. The block forms the register's load, clear and increment controls as sums of products of their lines, together with a register-reference qualifier and selected instruction bits. The controls are not free pins: each product term both enables a write and picks which result is written.

The datapath evaluates all four candidate results continuously: bitwise AND with the data register, 16-bit sum with the data register, a straight copy of the data register, and the zero-extended 8-bit input register. The register captures the selected result on the rising edge that closes the enabling timing state. A carry flag follows the most recent addition and holds between additions.

The surrounding sequencer, decoder, fetch logic and memory drive the inputs. The accumulator value and the carry are read straight from the outputs.

Top module: `acc_unit`

## Requirements
- R1: A synchronous active-high reset sets the accumulator to 0x0000 and the carry to 0 on the next rising edge.
- R2: With decoder line 1 and timing line 4 both high, the next edge latches the low 16 bits of accumulator + DR and latches the adder's carry-out into the carry output on that same edge.
- R3: With decoder line 0 and timing line 4 both high, the next edge latches the bitwise AND of the accumulator and DR.
- R4: With decoder line 2 and timing line 4 both high, the next edge latches DR unchanged.
- R5: With the register-reference input, instruction bit 6 and timing line 3 all high, the next edge latches the 8-bit input register into accumulator bits 7:0 and sets bits 15:8 to zero.
- R6: With the register-reference input and instruction bit 11 both high, the next edge sets the accumulator to zero.
- R7: With the register-reference input and instruction bit 5 both high, the next edge adds one to the accumulator; 0xFFFF becomes 0x0000.
- R8: When several controls are raised together, clear wins over load and load wins over increment. Among simultaneous load terms the order is ADD, then AND, then DR transfer, then input transfer.
- R9: The carry output keeps its value on every edge that does not latch an addition result. This includes an edge where clear overrides an addition.
- R10: With no product term true, the accumulator holds its value. Examples are decoder lines at a timing state other than their own, decoder line 3 or above, the register-reference input without bits 5, 6 or 11, and bit 6 outside timing state 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_i | input | 8 | One-hot opcode decoder lines |
| tst_i | input | 16 | One-hot timing-state lines |
| ref_i | input | 1 | Register-reference instruction condition |
| ir_i | input | 16 | Instruction register bits |
| dr_i | input | 16 | Data register operand |
| inpr_i | input | 8 | Input register byte |
| acc_o | output | 16 | Accumulator value |
| carry_o | output | 1 | Carry from the last latched addition |

## Verification
Every result of this block appears on the outputs one rising edge after the decoder, timing and instruction inputs that request it. The accumulator and the carry are both single registers behind a combinational datapath. The driver applies each stimulus on a falling edge and queues the expected accumulator and carry for that stimulus. The monitor compares just after the following rising edge, so each comparison lands on the first cycle in which the new value is valid and before the next stimulus can disturb it.

// File: rtl/acc_pkg.sv
package acc_pkg;
    parameter int ACC_W  = 16;
    parameter int INPR_W = 8;
    parameter int DEC_N  = 8;
    parameter int TST_N  = 16;
    parameter int IR_W   = 16;

    // timing states and instruction bits that gate the controls
    parameter int EXEC_T  = 4;
    parameter int IN_T    = 3;
    parameter int IN_BIT  = 6;
    parameter int CLR_BIT = 11;
    parameter int INC_BIT = 5;

    // decoder lines of the memory-operand ops, listed in select priority
    localparam int N_EXEC = 3;
    localparam int EXEC_DEC [N_EXEC] = '{1, 0, 2};
    localparam int N_TERM = N_EXEC + 1;

    typedef enum logic [1:0] {
        SRC_ADD = 2'd0,
        SRC_AND = 2'd1,
        SRC_DR  = 2'd2,
        SRC_IN  = 2'd3
    } src_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             carry;
    } acc_state_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic [DEC_N-1:0] dec_i,
    input  logic [TST_N-1:0] tst_i,
    input  logic             ref_i,
    input  logic [IR_W-1:0]  ir_i,
    output logic             ld_o,
    output logic             clr_o,
    output logic             inr_o,
    output src_e             src_o
);
    logic [N_TERM-1:0] term;
    logic              unused_lines;

    genvar g;
    generate
        for (g = 0; g < N_EXEC; g++) begin : g_exec
            assign term[g] = dec_i[EXEC_DEC[g]] & tst_i[EXEC_T];
        end
    endgenerate

    assign term[N_TERM-1] = ref_i & ir_i[IN_BIT] & tst_i[IN_T];

    assign ld_o  = |term;
    assign clr_o = ref_i & ir_i[CLR_BIT];
    assign inr_o = ref_i & ir_i[INC_BIT];

    // lowest index wins; term order equals src_e encoding
    always_comb begin
        src_o = SRC_IN;
        for (int i = N_TERM - 1; i >= 0; i--) begin
            if (term[i]) src_o = src_e'(i);
        end
    end

    assign unused_lines = ^{dec_i, tst_i, ir_i};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [ACC_W-1:0]  dr_i,
    input  logic [INPR_W-1:0] inpr_i,
    input  src_e              src_i,
    output logic [ACC_W-1:0]  res_o,
    output logic              cout_o
);
    logic [ACC_W:0] sum;

    assign sum    = {1'b0, acc_i} + {1'b0, dr_i};
    assign cout_o = sum[ACC_W];

    always_comb begin
        unique case (src_i)
            SRC_ADD: res_o = sum[ACC_W-1:0];
            SRC_AND: res_o = acc_i & dr_i;
            SRC_DR:  res_o = dr_i;
            SRC_IN:  res_o = {{(ACC_W-INPR_W){1'b0}}, inpr_i};
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DEC_N-1:0]  dec_i,
    input  logic [TST_N-1:0]  tst_i,
    input  logic              ref_i,
    input  logic [IR_W-1:0]   ir_i,
    input  logic [ACC_W-1:0]  dr_i,
    input  logic [INPR_W-1:0] inpr_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              carry_o
);
    acc_state_t       st_d, st_q;
    logic             ld, clr, inr;
    src_e             src;
    logic [ACC_W-1:0] res;
    logic             cout;

    acc_ctrl u_ctrl (
        .dec_i (dec_i),
        .tst_i (tst_i),
        .ref_i (ref_i),
        .ir_i  (ir_i),
        .ld_o  (ld),
        .clr_o (clr),
        .inr_o (inr),
        .src_o (src)
    );

    acc_alu u_alu (
        .acc_i  (st_q.acc),
        .dr_i   (dr_i),
        .inpr_i (inpr_i),
        .src_i  (src),
        .res_o  (res),
        .cout_o (cout)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (ld) begin
            st_d.acc = res;
            if (src == SRC_ADD) st_d.carry = cout;
        end else if (inr) begin
            st_d.acc = st_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_o   = st_q.acc;
    assign carry_o = st_q.carry;
endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DEC_N-1:0]  dec_i,
    input logic [TST_N-1:0]  tst_i,
    input logic              ref_i,
    input logic [IR_W-1:0]   ir_i,
    input logic [ACC_W-1:0]  dr_i,
    input logic [INPR_W-1:0] inpr_i,
    input logic [ACC_W-1:0]  acc_o,
    input logic              carry_o
);
    logic c_add, c_and, c_dr, c_in, c_clr, c_inr, c_ld;

    assign c_add = dec_i[1] & tst_i[EXEC_T];
    assign c_and = dec_i[0] & tst_i[EXEC_T];
    assign c_dr  = dec_i[2] & tst_i[EXEC_T];
    assign c_in  = ref_i & ir_i[IN_BIT] & tst_i[IN_T];
    assign c_clr = ref_i & ir_i[CLR_BIT];
    assign c_inr = ref_i & ir_i[INC_BIT];
    assign c_ld  = c_add | c_and | c_dr | c_in;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        c_clr |=> acc_o == '0); // R6

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (c_add && !c_clr) |=> {carry_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(dr_i)})); // R2

    AST_DR_COPY: assert property (@(posedge clk) disable iff (rst)
        (c_dr && !c_add && !c_and && !c_clr) |=> acc_o == $past(dr_i)); // R4

    AST_IN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (c_in && !c_add && !c_and && !c_dr && !c_clr) |=> acc_o == {{(ACC_W-INPR_W){1'b0}}, $past(inpr_i)}); // R5

    AST_INR_STEP: assert property (@(posedge clk) disable iff (rst)
        (c_inr && !c_ld && !c_clr) |=> acc_o == $past(acc_o) + 1'b1); // R7

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(c_add && !c_clr) |=> $stable(carry_o)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(c_ld || c_clr || c_inr) |=> $stable(acc_o)); // R10
endmodule

bind acc_unit acc_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dec_i   (dec_i),
    .tst_i   (tst_i),
    .ref_i   (ref_i),
    .ir_i    (ir_i),
    .dr_i    (dr_i),
    .inpr_i  (inpr_i),
    .acc_o   (acc_o),
    .carry_o (carry_o)
);

// File: tb/acc_unit_bench.sv
module acc_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  dec;
    logic [15:0] tst;
    logic        rref;
    logic [15:0] ir;
    logic [15:0] dr;
    logic [7:0]  inpr;
    logic [15:0] acc;
    logic        carry;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] m_acc = '0;
    logic        m_carry = 1'b0;

    logic [15:0] q_acc[$];
    logic        q_carry[$];
    string       q_tag[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_unit u_acc_unit (
        .clk     (clk),
        .rst     (rst),
        .dec_i   (dec),
        .tst_i   (tst),
        .ref_i   (rref),
        .ir_i    (ir),
        .dr_i    (dr),
        .inpr_i  (inpr),
        .acc_o   (acc),
        .carry_o (carry)
    );

    // driver: one stimulus per cycle, expected state queued for the next edge
    task automatic drive(input bit rs, input logic [7:0] d, input logic [15:0] t,
                         input bit r, input logic [15:0] i, input logic [15:0] dv,
                         input logic [7:0] inp, input string tag);
        logic a_add, a_and, a_dr, a_in, a_clr, a_inr;
        logic [16:0] s;
        @(negedge clk);
        rst = rs; dec = d; tst = t; rref = r; ir = i; dr = dv; inpr = inp;
        a_add = d[1] & t[4];
        a_and = d[0] & t[4];
        a_dr  = d[2] & t[4];
        a_in  = r & i[6] & t[3];
        a_clr = r & i[11];
        a_inr = r & i[5];
        if (rs) begin
            m_acc = '0; m_carry = 1'b0;
        end else if (a_clr) begin
            m_acc = '0;
        end else if (a_add) begin
            s = {1'b0, m_acc} + {1'b0, dv};
            m_acc = s[15:0]; m_carry = s[16];
        end else if (a_and) begin
            m_acc = m_acc & dv;
        end else if (a_dr) begin
            m_acc = dv;
        end else if (a_in) begin
            m_acc = {8'h00, inp};
        end else if (a_inr) begin
            m_acc = m_acc + 16'd1;
        end
        q_acc.push_back(m_acc);
        q_carry.push_back(m_carry);
        q_tag.push_back(tag);
    endtask

    // monitor: compare just after the edge that produced each result
    always @(posedge clk) begin
        #1;
        if (q_acc.size() > 0) begin
            logic [15:0] ea;
            logic ec;
            string tg;
            ea = q_acc.pop_front();
            ec = q_carry.pop_front();
            tg = q_tag.pop_front();
            total++;
            if (acc !== ea || carry !== ec) begin
                bad++;
                $display("FAIL %s acc=%h exp=%h carry=%b exp=%b", tg, acc, ea, carry, ec);
            end
        end
    end

    function automatic logic [7:0] dl(input int n);
        return 8'(1) << n;
    endfunction

    function automatic logic [15:0] tl(input int n);
        return 16'(1) << n;
    endfunction

    initial begin
        rst = 1'b1; dec = '0; tst = '0; rref = 1'b0; ir = '0; dr = '0; inpr = '0;
        drive(1, '0, '0, 0, '0, '0, '0, "R1 reset");
        drive(1, '0, '0, 0, '0, 16'hFFFF, 8'hFF, "R1 reset held");
        drive(0, dl(2), tl(4), 0, '0, 16'h1234, '0, "R4 load DR");
        drive(0, dl(1), tl(4), 0, '0, 16'h0001, '0, "R2 add no carry");
        drive(0, dl(1), tl(4), 0, '0, 16'hF00F, '0, "R2 add with carry");
        drive(0, dl(0), tl(4), 0, '0, 16'h0FF0, '0, "R3 and, R9 carry holds");
        drive(0, '0, tl(3), 1, 16'h0040, '0, 8'hAB, "R5 input byte");
        drive(0, '0, tl(7), 1, 16'h0020, '0, '0, "R7 increment");
        drive(0, dl(2), tl(4), 0, '0, 16'hFFFF, '0, "R4 load all ones");
        drive(0, '0, tl(9), 1, 16'h0020, '0, '0, "R7 increment wraps");
        drive(0, dl(2), tl(4), 0, '0, 16'h8001, '0, "R4 load");
        drive(0, '0, tl(0), 1, 16'h0800, '0, '0, "R6 clear");
        drive(0, dl(2), tl(4), 0, '0, 16'hFFFF, '0, "R4 reload");
        drive(0, dl(1), tl(4), 1, 16'h0800, 16'h0001, '0, "R8 clear over add, R9 carry held");
        drive(0, dl(2), tl(4), 1, 16'h0020, 16'h5A5A, '0, "R8 load over increment");
        drive(0, dl(0) | dl(1), tl(4), 0, '0, 16'h0101, '0, "R8 add over and");
        drive(0, dl(0) | dl(2), tl(4), 0, '0, 16'h00FF, '0, "R8 and over DR");
        drive(0, dl(2), tl(4) | tl(3), 1, 16'h0040, 16'h7777, 8'h11, "R8 DR over input");
        drive(0, dl(1), tl(5), 0, '0, 16'h1111, '0, "R10 add off-state");
        drive(0, dl(3), tl(4), 0, '0, 16'h2222, '0, "R10 other decoder line");
        drive(0, '0, tl(3), 1, 16'h0000, '0, 8'h33, "R10 ref without bits");
        drive(0, '0, tl(4), 1, 16'h0040, '0, 8'h44, "R10 input bit off-state");
        drive(0, '0, tl(3), 0, 16'h0840, '0, 8'h55, "R10 bits without ref");
        drive(0, dl(1), tl(4), 0, '0, 16'hFFFF, '0, "R2 add to set carry");
        drive(1, dl(1), tl(4), 0, '0, 16'hFFFF, '0, "R1 reset mid-run");
        drive(0, '0, '0, 0, '0, '0, '0, "R10 idle after reset");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule